// File: doc/BRIEF.md
# Dual-Lane Sample Router with Output Clock

This block sits behind a converter core that delivers one sample on every input clock. It spreads those samples over two output lanes, A and B, and produces the data clock that downstream logic uses to capture them. Three static select pins choose the routing. Lane A can run alone at full rate, or with lane B as a copy. The two lanes can form a 1-to-2 demultiplexer at half rate. Samples can be decimated by two or by five, with or without the lane B copy.

The select pins are captured only while the synchronous reset is held. Reset also clears the sample-phase counter, so the first output group after reset always begins with the first sample presented after reset is released. The data clock rises while lane data is stable, so a capturing flop on its rising edge sees each update exactly once. In the divided modes the data clock has a 50% duty cycle, and this holds for the odd ratio as well.

Top module: `dual_lane_router`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both lanes are cleared to zero and `dclk` is low after that edge.
- R2: With `div_en`=0 and `mirror_en`=0, and whatever the value of `slow_sel`, `lane_a` shows the sample captured at each rising edge one clock later, and `lane_b` stays zero.
- R3: With `div_en`=0 and `mirror_en`=1, and whatever the value of `slow_sel`, both lanes show the same sample, updated at every edge.
- R4: With `div_en`=1, `slow_sel`=0 and `mirror_en`=0, the lanes update together on every second edge. `lane_a` takes the newer sample of the pair and `lane_b` the older one, and the first sample after reset is the older sample of the first pair.
- R5: With `div_en`=1, `slow_sel`=0 and `mirror_en`=1, both lanes take the second sample of each pair, and the first sample of each pair is dropped.
- R6: With `div_en`=1, `slow_sel`=1 and `mirror_en`=0, `lane_a` takes the 5th, 10th, 15th and later samples after reset (every fifth), the other samples are dropped, and `lane_b` stays zero.
- R7: With `div_en`=1, `slow_sel`=1 and `mirror_en`=1, both lanes take the same sample, which is every fifth sample.
- R8: In the full-rate modes `dclk` is the inverse of `clk`. It is low in the first half of each clock period and high in the second half.
- R9: In the half-rate modes `dclk` is high for one whole clock out of every two, and it rises one clock after the lanes update.
- R10: In the divide-by-five modes `dclk` has a period of five clocks and is high for 2.5 of them. It rises half a clock into the third clock after a lane update and falls at the rising edge that brings the next update.
- R11: Changes on `div_en`, `slow_sel` or `mirror_en` while `rst` is low have no effect on the lanes or on `dclk` until the next reset.
- R12: In the divided modes both lanes hold their values on every edge that is not an update edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high; also captures the mode selects |
| div_en | input | 1 | 0: full rate; 1: divided output rate |
| slow_sel | input | 1 | With `div_en`=1, selects divide-by-five over divide-by-two |
| mirror_en | input | 1 | 1: lane B repeats lane A |
| sample_in | input | SAMPLE_W | Incoming sample |
| lane_a | output | SAMPLE_W | Output lane A |
| lane_b | output | SAMPLE_W | Output lane B |
| dclk | output | 1 | Output data clock; capture lanes on its rising edge |

## Verification
The embedded properties assume that `rst` is high from time zero. They also assume that the mode selects only matter on edges where reset is high, so the latched mode is treated as constant during any reset-free interval. The stimulus follows both assumptions: each run drives the mode pins before asserting reset and holds reset for two edges. Part-way through each run it then scrambles the selects with reset low, which checks that they are ignored. Samples form an incrementing sequence from a seeded random base, and some directed bases wrap through 8'hFF. This lets the drop pattern and the pair ordering be recovered from the value alone.

// File: rtl/dual_lane_router_pkg.sv
package dual_lane_router_pkg;

   typedef enum logic [2:0] {
      RM_FULL_A  = 3'd0,
      RM_FULL_AB = 3'd1,
      RM_DEMUX   = 3'd2,
      RM_HALF_AB = 3'd3,
      RM_SLOW_A  = 3'd4,
      RM_SLOW_AB = 3'd5
   } route_mode_e;

   function automatic route_mode_e decode_mode(input logic d_en,
                                               input logic s_sel,
                                               input logic m_en);
      route_mode_e r;
      if (!d_en)       r = m_en ? RM_FULL_AB : RM_FULL_A;
      else if (!s_sel) r = m_en ? RM_HALF_AB : RM_DEMUX;
      else             r = m_en ? RM_SLOW_AB : RM_SLOW_A;
      return r;
   endfunction

   function automatic logic is_divided(input route_mode_e m);
      return (m != RM_FULL_A) && (m != RM_FULL_AB);
   endfunction

   function automatic logic is_slow(input route_mode_e m);
      return (m == RM_SLOW_A) || (m == RM_SLOW_AB);
   endfunction

   function automatic logic is_mirror(input route_mode_e m);
      return (m == RM_FULL_AB) || (m == RM_HALF_AB) || (m == RM_SLOW_AB);
   endfunction

   function automatic logic is_single(input route_mode_e m);
      return (m == RM_FULL_A) || (m == RM_SLOW_A);
   endfunction

endpackage

// File: rtl/mode_latch.sv
module mode_latch
   import dual_lane_router_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        div_en,
   input  logic        slow_sel,
   input  logic        mirror_en,
   output route_mode_e mode_q
);

   always_ff @(posedge clk) begin
      if (rst) mode_q <= decode_mode(div_en, slow_sel, mirror_en);
   end

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(mode_q)); // R11

endmodule

// File: rtl/rate_counter.sv
module rate_counter
   import dual_lane_router_pkg::*;
#(
   parameter int HALF_RATIO = 2,
   parameter int SLOW_RATIO = 5,
   parameter int CW         = $clog2(SLOW_RATIO)
)(
   input  logic          clk,
   input  logic          rst,
   input  route_mode_e   mode,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt,
   output logic          wrap
);

   localparam logic [CW-1:0] HALF_LAST = CW'(HALF_RATIO - 1);
   localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_RATIO - 1);

   logic [CW-1:0] last;

   always_comb begin
      if (!is_divided(mode))  last = '0;
      else if (is_slow(mode)) last = SLOW_LAST;
      else                    last = HALF_LAST;
   end

   assign wrap    = (cnt_q == last);
   assign cnt_nxt = wrap ? '0 : cnt_q + CW'(1);

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_nxt;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= last); // R12

endmodule

// File: rtl/dclk_shaper.sv
module dclk_shaper #(
   parameter int RATIO = 5,
   parameter int CW    = 3
)(
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt_nxt,
   output logic          dclk_o
);

   logic rise_ph;

   generate
      if (RATIO % 2 == 0) begin : g_even
         localparam logic [CW-1:0] HI_FROM = CW'(RATIO / 2);
         always_ff @(posedge clk) begin
            if (rst) rise_ph <= 1'b0;
            else     rise_ph <= (cnt_nxt >= HI_FROM);
         end
         assign dclk_o = rise_ph;
      end else begin : g_odd
         localparam logic [CW-1:0] HI_FROM = CW'((RATIO - 1) / 2);
         logic fall_ph;
         always_ff @(posedge clk) begin
            if (rst) rise_ph <= 1'b0;
            else     rise_ph <= (cnt_nxt >= HI_FROM);
         end
         always_ff @(negedge clk) begin
            if (rst) fall_ph <= 1'b0;
            else     fall_ph <= rise_ph;
         end
         assign dclk_o = rise_ph & fall_ph;
      end
   endgenerate

endmodule

// File: rtl/lane_steer.sv
module lane_steer
   import dual_lane_router_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int CW       = 3
)(
   input  logic                clk,
   input  logic                rst,
   input  route_mode_e         mode,
   input  logic [CW-1:0]       cnt_q,
   input  logic                wrap,
   input  logic [SAMPLE_W-1:0] samp,
   output logic [SAMPLE_W-1:0] port_a,
   output logic [SAMPLE_W-1:0] port_b
);

   logic [SAMPLE_W-1:0] older;
   logic [SAMPLE_W-1:0] b_next;

   always_comb begin
      if (is_mirror(mode))       b_next = samp;
      else if (mode == RM_DEMUX) b_next = older;
      else                       b_next = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         older  <= '0;
         port_a <= '0;
         port_b <= '0;
      end else begin
         older <= samp;
         if (wrap) begin
            port_a <= samp;
            port_b <= b_next;
         end
      end
   end

   AST_B_IDLE: assert property (@(posedge clk) disable iff (rst)
      is_single(mode) |-> (port_b == '0)); // R2

   AST_MIRROR_SAME: assert property (@(posedge clk) disable iff (rst)
      is_mirror(mode) |-> (port_a == port_b)); // R3

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (is_divided(mode) && cnt_q != '0) |-> ($stable(port_a) && $stable(port_b))); // R12

endmodule

// File: rtl/dual_lane_router.sv
module dual_lane_router
   import dual_lane_router_pkg::*;
#(
   parameter int SAMPLE_W   = 8,
   parameter int HALF_RATIO = 2,
   parameter int SLOW_RATIO = 5
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                div_en,
   input  logic                slow_sel,
   input  logic                mirror_en,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic [SAMPLE_W-1:0] lane_a,
   output logic [SAMPLE_W-1:0] lane_b,
   output logic                dclk
);

   localparam int CW = (SLOW_RATIO > 2) ? $clog2(SLOW_RATIO) : 1;

   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("SAMPLE_W must be at least 1");
      end
      if (HALF_RATIO < 2 || SLOW_RATIO < HALF_RATIO) begin : g_bad_ratio
         $error("ratios must satisfy 2 <= HALF_RATIO <= SLOW_RATIO");
      end
   endgenerate

   route_mode_e   mode_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          wrap;
   logic          dclk_half;
   logic          dclk_slow;

   mode_latch u_mode (
      .clk       (clk),
      .rst       (rst),
      .div_en    (div_en),
      .slow_sel  (slow_sel),
      .mirror_en (mirror_en),
      .mode_q    (mode_q)
   );

   rate_counter #(
      .HALF_RATIO (HALF_RATIO),
      .SLOW_RATIO (SLOW_RATIO),
      .CW         (CW)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_q),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .wrap    (wrap)
   );

   dclk_shaper #(.RATIO(HALF_RATIO), .CW(CW)) u_dclk_half (
      .clk     (clk),
      .rst     (rst),
      .cnt_nxt (cnt_nxt),
      .dclk_o  (dclk_half)
   );

   dclk_shaper #(.RATIO(SLOW_RATIO), .CW(CW)) u_dclk_slow (
      .clk     (clk),
      .rst     (rst),
      .cnt_nxt (cnt_nxt),
      .dclk_o  (dclk_slow)
   );

   lane_steer #(.SAMPLE_W(SAMPLE_W), .CW(CW)) u_steer (
      .clk    (clk),
      .rst    (rst),
      .mode   (mode_q),
      .cnt_q  (cnt_q),
      .wrap   (wrap),
      .samp   (sample_in),
      .port_a (lane_a),
      .port_b (lane_b)
   );

   always_comb begin
      if (!is_divided(mode_q))  dclk = ~clk;
      else if (is_slow(mode_q)) dclk = dclk_slow;
      else                      dclk = dclk_half;
   end

   AST_DCLK_LOW_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
      (is_divided(mode_q) && cnt_q == '0) |-> !dclk); // R9

endmodule

// File: tb/tb_dual_lane_router.sv
`timescale 1ns/1ps
module tb_dual_lane_router;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       div_en = 1'b0;
   logic       slow_sel = 1'b0;
   logic       mirror_en = 1'b0;
   logic [7:0] sample_in = 8'h00;
   logic [7:0] lane_a;
   logic [7:0] lane_b;
   logic       dclk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_lane_router #(.SAMPLE_W(8), .HALF_RATIO(2), .SLOW_RATIO(5)) dut (
      .clk(clk), .rst(rst), .div_en(div_en), .slow_sel(slow_sel),
      .mirror_en(mirror_en), .sample_in(sample_in),
      .lane_a(lane_a), .lane_b(lane_b), .dclk(dclk)
   );

   // md: 0 full A, 1 full AB, 2 demux, 3 half AB, 4 slow A, 5 slow AB
   function automatic int ratio_of(int md);
      return (md < 2) ? 1 : ((md < 4) ? 2 : 5);
   endfunction

   function automatic logic [7:0] exp_lane(int md, int k, logic [7:0] base, bit is_b);
      int r = ratio_of(md);
      int g = (k + 1) / r;
      int u;
      logic [7:0] a;
      if (g == 0) return 8'h00;
      u = g * r - 1;
      a = base + 8'(u);
      if (!is_b || (md % 2 == 1)) return a;
      if (md == 2) return a - 8'd1;
      return 8'h00;
   endfunction

   function automatic logic exp_dclk(int md, int k, bit neg_phase);
      int r = ratio_of(md);
      int c;
      if (r == 1) return neg_phase;
      c = neg_phase ? (k % r) : ((k + 1) % r);
      if (r % 2 == 0) return c >= r / 2;
      return neg_phase ? (c >= (r - 1) / 2) : (c >= (r + 1) / 2);
   endfunction

   function automatic string lane_req(int md);
      case (md)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic string clk_req(int md);
      int r = ratio_of(md);
      return (r == 1) ? "R8" : ((r == 2) ? "R9" : "R10");
   endfunction

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_mode(int md, int n, logic [7:0] base);
      string rq;
      div_en    = (md >= 2);
      slow_sel  = (md >= 4);
      mirror_en = (md % 2 == 1);
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      chk("R1", "lane_a in reset", lane_a, 8'h00);
      chk("R1", "lane_b in reset", lane_b, 8'h00);
      chk("R1", "dclk in reset", {7'd0, dclk}, 8'h00);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
         if (k > 0) begin
            rq = (k > 8) ? "R11" : clk_req(md);
            chk(rq, "dclk low phase", {7'd0, dclk}, {7'd0, exp_dclk(md, k, 1'b1)});
         end
         if (k == 0) rst = 1'b0;
         if (k == 7) begin
            // R11: scramble selects with reset low
            div_en    = ~div_en;
            slow_sel  = 1'($urandom);
            mirror_en = ~mirror_en;
         end
         sample_in = base + 8'(k);
         @(posedge clk);
         #1;
         if (k > 8) rq = "R11";
         else if (ratio_of(md) > 1 && ((k + 1) % ratio_of(md)) != 0) rq = "R12";
         else rq = lane_req(md);
         chk(rq, "lane_a", lane_a, exp_lane(md, k, base, 1'b0));
         chk(rq, "lane_b", lane_b, exp_lane(md, k, base, 1'b1));
         rq = (k > 8) ? "R11" : clk_req(md);
         chk(rq, "dclk high phase", {7'd0, dclk}, {7'd0, exp_dclk(md, k, 1'b0)});
      end
   endtask

   initial begin
      void'($urandom(32'd1729));
      for (int md = 0; md < 6; md++) run_mode(md, 24, 8'hFB);
      for (int md = 0; md < 6; md++) run_mode(md, 12, 8'h00);
      for (int i = 0; i < 14; i++) begin
         run_mode(int'($urandom % 6), 16 + int'($urandom % 20), 8'($urandom));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #400000;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
         end
      join_any
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule